// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent 24-bit down counters behind a plain 32-bit register port: an address, a write strobe, write data and combinational read data. Software programs a start value and a control word for each counter. Each counter then steps down once every (prescale + 1) clocks. When it passes from 1 to 0 it marks a status flag. In periodic mode it refills itself from the start value. In one-shot mode it stops itself.

Both status flags live in one shared register. Software clears a flag by writing a 1 to its bit. Each counter drives its own level interrupt, which is high while its flag is set and its interrupt enable is on. Either counter's current value can be read at any time. The block suits an operating-system tick, where one counter raises periodic or one-shot events, and a free-running timebase, where the other counter is read as a falling value.

Top module: `dtmr_top`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Register map by byte offset: control 0 at 0x00, control 1 at 0x04, start value 0 at 0x08, start value 1 at 0x0C, live count 0 at 0x10, live count 1 at 0x14, status at 0x18. Control word fields: bit 30 is run, bit 29 is interrupt enable, bit 27 is periodic (1) or one-shot (0), and bits 7:0 are the prescale. Every other control bit reads 0. Start values read back as 24 bits with the top byte zero.
- R3: While running, the count drops by one on every (prescale + 1)th clock. The first decrement comes (prescale + 1) clocks after a load.
- R4: Writing a start value loads it into the count at once and restarts the prescale phase, even while the counter runs.
- R5: Writing run = 1 while run is 0 loads the start value if the count is 0. If the count is non-zero, it resumes from the held count.
- R6: While run is 0 the count holds its value.
- R7: A step from 1 to 0 sets the status flag (bit 0 for counter 0, bit 1 for counter 1), whether or not the interrupt is enabled.
- R8: In periodic mode the expiring step reloads the start value, and run stays set.
- R9: In one-shot mode the expiring step leaves the count at 0 and clears run in hardware.
- R10: Each interrupt output is high exactly while its status flag and its interrupt enable are both set.
- R11: Writing the status register clears each flag whose write bit is 1. Flags written with 0 are unchanged.
- R12: A running counter whose count is 0 stays at 0 and never sets its flag.
- R13: Offsets outside the map read as zero and ignore writes. The two live-count registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 2 | Level interrupts, bit i for counter i |

## Verification
The bench targets the edge cases that cause off-by-one errors.

It measures the exact expiry cycle with a prescale above zero. A design that ticks on the load cycle, or after prescale clocks instead of prescale + 1, expires early.

It stops a counter, checks that the value is frozen, and restarts it. A design that always reloads on run, or that drifts while stopped, misses the predicted expiry. It also restarts a one-shot counter that has run down to zero; a design that never reloads in that case never fires again.

Status handling is checked bit by bit. A partial clear that wipes both flags shows up, as does an interrupt that fires while its enable is off.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int CNT_W   = 24;
    localparam int PSC_W   = 8;
    localparam int NUM_TMR = 2;
    localparam int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    // control word bit positions
    localparam int BIT_RUN = 30;
    localparam int BIT_IEN = 29;
    localparam int BIT_PER = 27;

    // register bases; per-counter registers are spaced by one word
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_INIT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
    localparam int                WORD_B   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_INIT,
        SEL_DATA,
        SEL_STAT
    } rsel_e;

    typedef struct packed {
        rsel_e            sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic             run;
        logic             ien;
        logic             per;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run = w[BIT_RUN];
        c.ien = w[BIT_IEN];
        c.per = w[BIT_PER];
        c.psc = w[PSC_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_RUN]   = c.run;
        w[BIT_IEN]   = c.ien;
        w[BIT_PER]   = c.per;
        w[PSC_W-1:0] = c.psc;
        return w;
    endfunction

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
    import dtmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);

    always_comb begin
        dec_o.sel = SEL_NONE;
        dec_o.idx = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr_i == ADDR_W'(OFS_CTRL + WORD_B * i)) begin
                dec_o.sel = SEL_CTRL;
                dec_o.idx = IDX_W'(i);
            end
            if (addr_i == ADDR_W'(OFS_INIT + WORD_B * i)) begin
                dec_o.sel = SEL_INIT;
                dec_o.idx = IDX_W'(i);
            end
            if (addr_i == ADDR_W'(OFS_DATA + WORD_B * i)) begin
                dec_o.sel = SEL_DATA;
                dec_o.idx = IDX_W'(i);
            end
        end
        if (addr_i == OFS_STAT) begin
            dec_o.sel = SEL_STAT;
        end
    end

endmodule

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] phase_q;

    // >= keeps the divider sane if the prescale is lowered mid-period
    assign tick_o = en_i && !restart_i && (phase_q >= psc_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            phase_q <= '0;
        end else if (en_i) begin
            phase_q <= tick_o ? '0 : phase_q + 1'b1;
        end
    end

    // R3: with a non-zero prescale two ticks never come back to back
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0));

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr_i,
    input  ctrl_t            wcfg_i,
    input  logic             init_wr_i,
    input  logic [CNT_W-1:0] winit_i,
    input  logic             stat_clr_i,
    output ctrl_t            cfg_o,
    output logic [CNT_W-1:0] init_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             stat_o,
    output logic             irq_o
);

    ctrl_t            cfg_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stat_q;
    logic             tick;
    logic             start_empty;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;

    // a start from an empty count takes the start value; otherwise resume
    assign start_empty = ctrl_wr_i && wcfg_i.run && !cfg_q.run && (cnt_q == '0);
    assign load        = init_wr_i || start_empty;
    assign load_val    = init_wr_i ? winit_i : init_q;

    dtmr_prescaler u_psc (
        .clk       (clk),
        .rst       (rst),
        .en_i      (cfg_q.run),
        .restart_i (load),
        .psc_i     (cfg_q.psc),
        .tick_o    (tick)
    );

    assign expire = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            init_q <= '0;
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            if (ctrl_wr_i) begin
                cfg_q <= wcfg_i;
            end else if (expire && !cfg_q.per) begin
                cfg_q.run <= 1'b0;
            end

            if (init_wr_i) begin
                init_q <= winit_i;
            end

            if (load) begin
                cnt_q <= load_val;
            end else if (expire) begin
                cnt_q <= cfg_q.per ? init_q : '0;
            end else if (tick && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (expire) begin
                stat_q <= 1'b1;
            end else if (stat_clr_i) begin
                stat_q <= 1'b0;
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign init_o = init_q;
    assign cnt_o  = cnt_q;
    assign stat_o = stat_q;
    assign irq_o  = stat_q && cfg_q.ien;

    // R3: an ordinary tick lowers the count by exactly one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: a stopped counter with no load keeps its value
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !load) |=> (cnt_q == $past(cnt_q)));

    // R7: expiry always raises the flag
    p_flag_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> stat_q);

    // R8: periodic expiry refills from the start value and keeps running
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg_q.per && !ctrl_wr_i) |=> (cnt_q == $past(init_q) && cfg_q.run));

    // R9: one-shot expiry stops the counter at zero
    p_oneshot_r9: assert property (@(posedge clk) disable iff (rst)
        (expire && !cfg_q.per && !ctrl_wr_i) |=> (!cfg_q.run && cnt_q == '0));

    // R11: a clear without a concurrent expiry drops the flag
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_i && !expire) |=> !stat_q);

    // R12: an empty running counter never flags
    p_empty_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |-> !expire);

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] irq_o
);

    dec_t             dec;
    ctrl_t            wcfg;
    logic [CNT_W-1:0] winit;
    logic             unused_wbits;

    ctrl_t            ch_cfg  [NUM_TMR];
    logic [CNT_W-1:0] ch_init [NUM_TMR];
    logic [CNT_W-1:0] ch_cnt  [NUM_TMR];
    logic [NUM_TMR-1:0] ch_stat;

    dtmr_decode u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    assign wcfg         = ctrl_unpack(bus_wdata);
    assign winit        = bus_wdata[CNT_W-1:0];
    assign unused_wbits = ^{bus_wdata[31], bus_wdata[28], bus_wdata[26:24]};

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        logic ctrl_wr;
        logic init_wr;
        logic stat_clr;

        assign ctrl_wr  = bus_we && dec.sel == SEL_CTRL && dec.idx == IDX_W'(g);
        assign init_wr  = bus_we && dec.sel == SEL_INIT && dec.idx == IDX_W'(g);
        assign stat_clr = bus_we && dec.sel == SEL_STAT && bus_wdata[g];

        dtmr_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .ctrl_wr_i  (ctrl_wr),
            .wcfg_i     (wcfg),
            .init_wr_i  (init_wr),
            .winit_i    (winit),
            .stat_clr_i (stat_clr),
            .cfg_o      (ch_cfg[g]),
            .init_o     (ch_init[g]),
            .cnt_o      (ch_cnt[g]),
            .stat_o     (ch_stat[g]),
            .irq_o      (irq_o[g])
        );
    end

    always_comb begin
        unique case (dec.sel)
            SEL_CTRL: bus_rdata = ctrl_pack(ch_cfg[dec.idx]);
            SEL_INIT: bus_rdata = DATA_W'(ch_init[dec.idx]);
            SEL_DATA: bus_rdata = DATA_W'(ch_cnt[dec.idx]);
            SEL_STAT: bus_rdata = DATA_W'(ch_stat);
            default:  bus_rdata = '0;
        endcase
    end

    // R13: an unmapped offset never returns data
    p_unmapped_r13: assert property (@(posedge clk) disable iff (rst)
        (dec.sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/dtmr_top_tb_top.sv
module dtmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    longint cyc = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    longint last_edge = 0;
    bit     done = 1'b0;

    typedef struct {
        int     ch;
        longint at;
    } ev_t;
    ev_t exp_q[$];

    dtmr_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        last_edge = cyc;
    endtask

    task automatic wait_to(input longint t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic rd_at(input longint t, input logic [7:0] a, input logic [31:0] exp,
                         input string req, input string what);
        wait_to(t);
        bus_addr = a;
        #1;
        chk(req, what, bus_rdata, exp);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp,
                      input string req, input string what);
        rd_at(cyc, a, exp, req, what);
    endtask

    task automatic expect_irq(input int ch, input longint at);
        exp_q.push_back('{ch, at});
    endtask

    // monitor: every rising interrupt must match the head of the scoreboard
    logic [1:0] irq_prev = '0;
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                if (irq[i] && !irq_prev[i]) begin
                    n_chk++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL R10 unexpected irq%0d: actual cycle %0d expected none", i, cyc);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        if (e.ch != i || e.at != cyc) begin
                            n_bad++;
                            $display("FAIL R10 irq event: actual ch%0d@%0d expected ch%0d@%0d",
                                     i, cyc, e.ch, e.at);
                        end
                    end
                end
            end
            irq_prev = irq;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint w;
        longint h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, 32'h0, "R1", "ctrl0");
        rd(8'h04, 32'h0, "R1", "ctrl1");
        rd(8'h08, 32'h0, "R1", "init0");
        rd(8'h0C, 32'h0, "R1", "init1");
        rd(8'h10, 32'h0, "R1", "data0");
        rd(8'h14, 32'h0, "R1", "data1");
        rd(8'h18, 32'h0, "R1", "status");
        chk("R1", "irq", {30'b0, irq}, 32'h0);

        // R2 field readback, R12 empty running counter
        wr(8'h00, 32'hFFFF_FFFF);
        w = last_edge;
        rd(8'h00, 32'h6800_00FF, "R2", "ctrl0 defined bits");
        rd_at(w + 12, 8'h18, 32'h0, "R12", "status with empty count");
        rd(8'h10, 32'h0, "R12", "data0 stays zero");
        wr(8'h00, 32'h0);

        // R3 prescale 2, one-shot with interrupt, R9
        wr(8'h08, 32'd5);
        wr(8'h00, 32'h6000_0002);
        w = last_edge;
        expect_irq(0, w + 15);
        rd_at(w + 2, 8'h10, 32'd5, "R3", "data0 before first tick");
        rd_at(w + 4, 8'h10, 32'd4, "R3", "data0 after one period");
        rd_at(w + 6, 8'h10, 32'd3, "R3", "data0 after two periods");
        rd_at(w + 17, 8'h00, 32'h2000_0002, "R9", "ctrl0 run cleared");
        rd(8'h10, 32'h0, "R9", "data0 at zero");
        rd(8'h18, 32'h1, "R7", "status bit0");
        chk("R10", "irq0 high", {31'b0, irq[0]}, 32'h1);

        // R11 clear
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h0, "R11", "status cleared");
        chk("R10", "irq0 low after clear", {31'b0, irq[0]}, 32'h0);

        // R8 periodic counter 1
        wr(8'h0C, 32'd3);
        wr(8'h04, 32'h6800_0000);
        w = last_edge;
        expect_irq(1, w + 3);
        rd_at(w + 4, 8'h14, 32'd2, "R8", "data1 after reload");
        rd_at(w + 6, 8'h14, 32'd3, "R8", "data1 second reload");
        rd_at(w + 7, 8'h14, 32'd2, "R8", "data1 counting again");
        rd_at(w + 8, 8'h04, 32'h6800_0000, "R8", "ctrl1 still running");
        wr(8'h04, 32'h0);
        wr(8'h18, 32'h1F);
        rd(8'h18, 32'h0, "R11", "status after clear all");

        // R7/R10 flag with interrupt disabled
        wr(8'h08, 32'd2);
        wr(8'h00, 32'h4000_0000);
        w = last_edge;
        rd_at(w + 3, 8'h18, 32'h1, "R7", "flag without enable");
        chk("R10", "irq0 stays low", {31'b0, irq[0]}, 32'h0);
        wr(8'h18, 32'h1F);

        // R6 halt, R5 resume
        wr(8'h0C, 32'd100);
        wr(8'h04, 32'h4000_0000);
        w = last_edge;
        wr(8'h04, 32'h0);
        h = 100 - (last_edge - w);
        rd_at(last_edge + 1, 8'h14, 32'(h), "R6", "held count");
        rd_at(last_edge + 6, 8'h14, 32'(h), "R6", "still held");
        wr(8'h04, 32'h6000_0000);
        w = last_edge;
        expect_irq(1, w + h);
        rd_at(w + 10, 8'h14, 32'(h - 10), "R5", "resumed from held value");
        rd_at(w + h + 2, 8'h04, 32'h2000_0000, "R9", "ctrl1 one-shot stop");
        rd(8'h14, 32'h0, "R9", "data1 zero");
        wr(8'h18, 32'h2);
        wr(8'h04, 32'h6000_0000);
        w = last_edge;
        expect_irq(1, w + 100);
        rd_at(w + 1, 8'h14, 32'd99, "R5", "restart from empty loads");
        wait_to(w + 102);

        // R11 partial clears
        rd(8'h18, 32'h2, "R7", "status bit1");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h2, "R11", "other flag kept");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h2, "R11", "zero write kept");
        wr(8'h18, 32'h2);
        rd(8'h18, 32'h0, "R11", "bit1 cleared");

        // R4 reload while running
        wr(8'h08, 32'd50);
        wr(8'h00, 32'h4800_0000);
        wr(8'h08, 32'd7);
        w = last_edge;
        rd_at(w, 8'h10, 32'd7, "R4", "data0 reloaded");
        rd_at(w + 1, 8'h10, 32'd6, "R4", "data0 counting from new value");
        rd(8'h08, 32'd7, "R2", "init0 readback");
        wr(8'h00, 32'h0);

        // R2 24-bit start value, max count
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h00FF_FFFF, "R2", "init1 width");
        rd(8'h14, 32'h00FF_FFFF, "R4", "data1 max load");
        wr(8'h04, 32'h4000_0000);
        w = last_edge;
        rd_at(w + 1, 8'h14, 32'h00FF_FFFE, "R3", "max count decrements");
        wr(8'h04, 32'h0);
        h = 32'h00FF_FFFF - (last_edge - w);

        // R13 unmapped and read-only
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0, "R13", "unmapped read");
        rd(8'h02, 32'h0, "R13", "misaligned read");
        rd(8'h18, 32'h0, "R13", "status untouched");
        wr(8'h14, 32'h0);
        rd(8'h14, 32'(h), "R13", "data1 write ignored");

        repeat (3) @(negedge clk);
        chk("R10", "pending irq events", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule